// File: doc/BRIEF.md
# Divided Delayed Trigger Channel

This block is one output channel of a trigger generator. It receives a single-cycle source event strobe and a single-cycle sync strobe. Both are selected and conditioned upstream. From them it produces one single-cycle output trigger. A programmable event divider lets only every Nth source event through. The sync strobe can clear the divider's counter so that the channel's phase follows another channel.

Each divided pulse also starts a cycle-count delay stage. A run-time select bit chooses whether the output pin carries the direct pulse or the delayed copy. An enable bit gates the pin alone. A 32-bit counter records every generated pulse, whether or not the pin is enabled. The counter wraps modulo 2^32.

All configuration is static register input sampled every cycle. The block has no bus and no source selection logic.

Top module: `trig_channel`

## Requirements
- R1: A synchronous active-high reset clears the divider counter, the pending delay and the trigger count. After reset `trig_out` is 0 and `trig_count` is 0.
- R2: With `cfg_div` = N-1, one generated pulse follows every Nth source event. A value of 0 passes every event. If the counter is already at or above a newly lowered `cfg_div`, the counter wraps on the next event.
- R3: A generated pulse is exactly one cycle wide. It is visible in the cycle after the source event that wraps the divider counter to 0.
- R4: A sync strobe without a source event loads 0 into the divider counter and emits nothing. The next pulse then follows the Nth later event.
- R5: A sync strobe and a source event in the same cycle load 0 into the counter and emit a pulse (sync wins).
- R6: The delayed pulse appears `cfg_dly`+1 cycles after the direct pulse. With `cfg_dly` = 0 it is the direct pulse one cycle later.
- R7: The delay stage holds one pending pulse. A new direct pulse while a delay is pending restarts the countdown from `cfg_dly`, and the earlier pulse is dropped.
- R8: `cfg_dly_en` = 1 routes the delayed pulse to `trig_out`, and 0 routes the direct pulse. The bit may change in any cycle.
- R9: With `cfg_enable` = 0, `trig_out` stays 0, while the divider, the delay stage and `trig_count` keep operating.
- R10: `trig_count` rises by exactly one in the cycle after each generated direct pulse and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | 1 | Single-cycle source event strobe |
| sync_evt | input | 1 | Single-cycle sync strobe (phase alignment) |
| cfg_enable | input | 1 | Output pin enable |
| cfg_div | input | DIV_W (32) | Divide ratio minus one |
| cfg_dly_en | input | 1 | Select delayed (1) or direct (0) pulse |
| cfg_dly | input | DLY_W (32) | Delay in clock cycles |
| trig_out | output | 1 | Output trigger pulse |
| trig_count | output | CNT_W (32) | Count of generated pulses, wraps |

## Verification
Counter reset by the sync strobe and counter advance by a source event can fall in the same cycle. Directed steps place the sync strobe alone and together with an event at several counter phases. Random stimulus with a fixed seed then mixes both strobes at independent rates while the ratio changes. Each cycle the output is compared against a bench model, which states sync priority directly. The model tracks the delay as an absolute target cycle, so a restart during a pending delay is judged from when the new pulse arrives.

// File: rtl/trig_chan_pkg.sv
package trig_chan_pkg;
    localparam int unsigned TRG_DIV_W = 32;
    localparam int unsigned TRG_DLY_W = 32;
    localparam int unsigned TRG_CNT_W = 32;

    typedef enum logic {
        DLY_IDLE = 1'b0,
        DLY_WAIT = 1'b1
    } dly_state_e;
endpackage

// File: rtl/trig_divider.sv
module trig_divider
    import trig_chan_pkg::*;
#(
    parameter int unsigned DIV_W = TRG_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_evt,
    input  logic             sync_evt,
    input  logic [DIV_W-1:0] div_val,
    output logic             pulse
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pulse;
    } div_state_t;

    div_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (sync_evt) begin
            // sync has priority: phase restarts, a coincident event fires
            state_d.cnt   = '0;
            state_d.pulse = src_evt;
        end else if (src_evt) begin
            if (state_q.cnt >= div_val) begin
                state_d.cnt   = '0;
                state_d.pulse = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pulse = state_q.pulse;
endmodule

// File: rtl/trig_delay.sv
module trig_delay
    import trig_chan_pkg::*;
#(
    parameter int unsigned DLY_W = TRG_DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_in,
    input  logic [DLY_W-1:0] dly_val,
    output logic             pulse_out
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        dly_state_e       st;
        logic [DLY_W-1:0] rem;
        logic             fire;
    } dly_reg_t;

    dly_reg_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.fire = 1'b0;
        if (pulse_in) begin
            // a fresh pulse always restarts the single slot
            if (dly_val == '0) begin
                state_d.st   = DLY_IDLE;
                state_d.fire = 1'b1;
            end else begin
                state_d.st  = DLY_WAIT;
                state_d.rem = dly_val - ONE;
            end
        end else if (state_q.st == DLY_WAIT) begin
            if (state_q.rem == '0) begin
                state_d.st   = DLY_IDLE;
                state_d.fire = 1'b1;
            end else begin
                state_d.rem = state_q.rem - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.st   <= DLY_IDLE;
            state_q.rem  <= '0;
            state_q.fire <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse_out = state_q.fire;
endmodule

// File: rtl/trig_counter.sv
module trig_counter
    import trig_chan_pkg::*;
#(
    parameter int unsigned CNT_W = TRG_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc) count_d = count_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/trig_channel.sv
module trig_channel
    import trig_chan_pkg::*;
#(
    parameter int unsigned DIV_W = TRG_DIV_W,
    parameter int unsigned DLY_W = TRG_DLY_W,
    parameter int unsigned CNT_W = TRG_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_evt,
    input  logic             sync_evt,
    input  logic             cfg_enable,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_dly_en,
    input  logic [DLY_W-1:0] cfg_dly,
    output logic             trig_out,
    output logic [CNT_W-1:0] trig_count
);
    logic div_pulse;
    logic dly_pulse;
    logic sel_pulse;

    trig_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .src_evt  (src_evt),
        .sync_evt (sync_evt),
        .div_val  (cfg_div),
        .pulse    (div_pulse)
    );

    trig_delay #(.DLY_W(DLY_W)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .pulse_in  (div_pulse),
        .dly_val   (cfg_dly),
        .pulse_out (dly_pulse)
    );

    trig_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (div_pulse),
        .count (trig_count)
    );

    always_comb begin
        sel_pulse = cfg_dly_en ? dly_pulse : div_pulse;
        trig_out  = cfg_enable & sel_pulse;
    end
endmodule

// File: rtl/trig_channel_chk.sv
module trig_channel_chk #(
    parameter int unsigned DLY_W = 32,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             src_evt,
    input logic             sync_evt,
    input logic             cfg_enable,
    input logic [DLY_W-1:0] cfg_dly,
    input logic             div_pulse,
    input logic             dly_pulse,
    input logic             trig_out,
    input logic [CNT_W-1:0] trig_count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R3
    pulse_from_event_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(src_evt));

    // R4
    sync_alone_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_evt && !src_evt) |=> !div_pulse);

    // R5
    sync_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_evt && src_evt) |=> div_pulse);

    // R6
    zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && cfg_dly == '0) |=> dly_pulse);

    // R9
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> cfg_enable);

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> (trig_count == $past(trig_count) + ONE));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(trig_count));
endmodule

bind trig_channel trig_channel_chk #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_evt    (src_evt),
    .sync_evt   (sync_evt),
    .cfg_enable (cfg_enable),
    .cfg_dly    (cfg_dly),
    .div_pulse  (div_pulse),
    .dly_pulse  (dly_pulse),
    .trig_out   (trig_out),
    .trig_count (trig_count)
);

// File: tb/trig_channel_test.sv
`timescale 1ns/1ps
module trig_channel_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        src_evt, sync_evt, cfg_enable, cfg_dly_en;
    logic [31:0] cfg_div, cfg_dly;
    logic        trig_out;
    logic [31:0] trig_count;

    always #2 clk = ~clk;

    trig_channel uut (
        .clk(clk), .rst(rst), .src_evt(src_evt), .sync_evt(sync_evt),
        .cfg_enable(cfg_enable), .cfg_div(cfg_div), .cfg_dly_en(cfg_dly_en),
        .cfg_dly(cfg_dly), .trig_out(trig_out), .trig_count(trig_count)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    cmp_on = 1'b0;
    string tag    = "R1";

    // reference model built from the requirements
    logic [31:0] m_cnt;
    logic        m_pulse;
    logic [31:0] m_count;
    longint      m_cyc, m_target;
    bit          m_valid;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_pulse <= 1'b0; m_count <= '0;
            m_cyc <= 0; m_valid <= 1'b0; m_target <= 0;
        end else begin
            m_cyc <= m_cyc + 1;
            if (m_pulse) begin
                m_target <= m_cyc + 1 + longint'(cfg_dly);
                m_valid  <= 1'b1;
            end
            m_count <= m_count + {31'd0, m_pulse};
            if (sync_evt) begin
                m_cnt <= '0; m_pulse <= src_evt;
            end else if (src_evt && m_cnt >= cfg_div) begin
                m_cnt <= '0; m_pulse <= 1'b1;
            end else begin
                if (src_evt) m_cnt <= m_cnt + 32'd1;
                m_pulse <= 1'b0;
            end
        end
    end

    function automatic logic exp_out();
        logic d;
        d = m_valid && (m_cyc == m_target);
        return cfg_enable && (cfg_dly_en ? d : m_pulse);
    endfunction

    task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(tag, 64'(trig_out), 64'(exp_out()));
            check("R10", 64'(trig_count), 64'(m_count));
        end
    end

    task automatic step(input logic s, input logic y);
        @(posedge clk); #1;
        src_evt = s; sync_evt = y;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] c0;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; src_evt = 0; sync_evt = 0;
        cfg_enable = 1'b1; cfg_dly_en = 1'b0; cfg_div = 32'd0; cfg_dly = 32'd0;
        idle(3);
        rst = 1'b0;
        // R1: reset state
        src_evt = 1'b1;
        @(negedge clk);
        check("R1", 64'(trig_out), 64'd0);
        check("R1", 64'(trig_count), 64'd0);
        cmp_on = 1'b1;

        // R2: divide by 3, then pass-through
        tag = "R2"; cfg_div = 32'd2;
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        cfg_div = 32'd0;
        for (int i = 0; i < 20; i++) step(1'($urandom % 2), 1'b0);
        // R2: lowered ratio while counter is above it
        cfg_div = 32'd6;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        cfg_div = 32'd1;
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);

        // R3: isolated events, one-cycle pulses
        tag = "R3"; cfg_div = 32'd0;
        for (int i = 0; i < 4; i++) begin step(1'b1, 1'b0); idle(3); end
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        @(negedge clk);
        check("R3", 64'(trig_out), 64'd1);
        step(1'b0, 1'b0);
        @(negedge clk);
        check("R3", 64'(trig_out), 64'd0);

        // R4: sync alone mid-count
        tag = "R4"; cfg_div = 32'd3;
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);

        // R5: sync and event together
        tag = "R5";
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b1, 1'b1); step(1'b0, 1'b0);
        @(negedge clk);
        check("R5", 64'(trig_out), 64'd1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1); step(1'b1, 1'b1);
        idle(2);

        // R6: delay values 0 and 5
        tag = "R6"; cfg_div = 32'd0; cfg_dly_en = 1'b1; cfg_dly = 32'd0;
        for (int i = 0; i < 3; i++) begin step(1'b1, 1'b0); idle(3); end
        cfg_dly = 32'd5;
        for (int i = 0; i < 3; i++) begin step(1'b1, 1'b0); idle(9); end

        // R7: restart during a pending delay
        tag = "R7"; cfg_dly = 32'd10;
        step(1'b1, 1'b0); idle(3); step(1'b1, 1'b0); idle(16);
        step(1'b1, 1'b0); idle(10); step(1'b1, 1'b0); idle(14);

        // R8: run-time select
        tag = "R8"; cfg_dly = 32'd3;
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 0) cfg_dly_en = ~cfg_dly_en;
            step(1'(i % 2 == 0), 1'b0);
        end
        idle(6);

        // R9: output gated, count still advances
        tag = "R9"; cfg_enable = 1'b0; cfg_dly_en = 1'b0; cfg_div = 32'd0;
        @(negedge clk); c0 = trig_count;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        idle(2);
        @(negedge clk);
        check("R9", 64'(trig_count), 64'(c0 + 32'd10));
        cfg_enable = 1'b1;

        // R10: constrained random mix
        tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 50 == 0) cfg_div = $urandom % 5;
            if ($urandom % 60 == 0) cfg_dly = $urandom % 8;
            if ($urandom % 40 == 0) cfg_dly_en = ~cfg_dly_en;
            if ($urandom % 70 == 0) cfg_enable = ~cfg_enable;
            step(1'($urandom % 3 == 0), 1'($urandom % 23 == 0));
        end
        idle(12);
        @(negedge clk);
        finish_run();
    end
endmodule